// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block is a free-running machine timer for one hart. It holds a double-word count that advances on every clock and a double-word compare value. It raises a level interrupt request toward the trap logic when the count reaches the compare value as defined below. Both values are split into two bus words, a low half and a high half.

Software reaches the block over a simple register bus. The bus carries a full byte address, separate read and write strobes, write data and registered read data. The block answers at four fixed offsets from a base-address parameter. The compare halves can be read and written. The count halves can only be read. The word width is a parameter: 32 on silicon, smaller in verification so that the carry into the high word can be reached.

Top module: `mtimer`

## Requirements
- R1: While `rst_ni` is low, and at the moment it is released, the count, the compare value and `rd_data_o` are zero and `irq_o` is low.
- R2: The count low word (offset 0xBFF8) increases by one on every rising clock edge and wraps to zero after the all-ones value.
- R3: The count high word (offset 0xBFFC) increases by one on the same edge at which the low word wraps from all-ones to zero, and holds on every other edge.
- R4: `irq_o` is high exactly when the compare value is non-zero and either (count high > compare high) or (count high == compare high and count low == compare low). A count with an equal high word and a larger low word does not fire.
- R5: When both compare words are zero, `irq_o` stays low for every count value.
- R6: A write strobe at offset 0x4000 loads the compare low word, and one at offset 0x4004 loads the compare high word, on the next clock edge.
- R7: A write strobe at any other offset, including both count offsets and offset 0x0000, leaves the compare value and the count unchanged.
- R8: A read strobe at offsets 0x4000, 0x4004, 0xBFF8 or 0xBFFC puts onto `rd_data_o`, one cycle later, the value that register held in the strobe cycle.
- R9: A read strobe at any other offset returns zero on `rd_data_o` one cycle later.
- R10: `irq_o` is a level. It falls in the cycle after a compare write that makes the fire condition false.
- R11: The fire condition is evaluated on the count after the edge's increment, so `irq_o` is high during the cycle in which the count equals the compare value and low in the next cycle while the high words stay equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count advances on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | WORD_W | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | WORD_W | Registered read data, valid the cycle after the strobe |
| irq_o | output | 1 | Timer interrupt request, level |

## Verification
The bench uses a 4-bit word, so the whole 8-bit count cycles every 256 clocks. It walks all 256 compare values, and for each one it observes the interrupt over a full count period. This separates the greater-than branch on the high word, the exact-match branch and the all-zero disable. It also shows that an equal high word with a larger low word stays quiet. During the sweep, reads rotate over the four defined offsets and three undefined ones. This checks one-cycle read latency, the carry into the high word and the zero returned for undefined offsets. Directed sequences then cover writes to read-only and undefined offsets, a compare rewrite that drops an active request, and a match placed a few cycles ahead of the count.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int unsigned OFF_SWI    = 32'h0000_0000;
  localparam int unsigned OFF_CMP_LO = 32'h0000_4000;
  localparam int unsigned OFF_CMP_HI = 32'h0000_4004;
  localparam int unsigned OFF_CNT_LO = 32'h0000_BFF8;
  localparam int unsigned OFF_CNT_HI = 32'h0000_BFFC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CNT_LO,
    SEL_CNT_HI
  } reg_sel_e;

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]      BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  logic [ADDR_W-1:0] offset;

  assign offset = addr_i - BASE_ADDR;

  always_comb begin
    unique case (offset)
      ADDR_W'(OFF_CMP_LO): sel_o = SEL_CMP_LO;
      ADDR_W'(OFF_CMP_HI): sel_o = SEL_CMP_HI;
      ADDR_W'(OFF_CNT_LO): sel_o = SEL_CNT_LO;
      ADDR_W'(OFF_CNT_HI): sel_o = SEL_CNT_HI;
      default:             sel_o = SEL_NONE;  // includes OFF_SWI
    endcase
  end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [WORD_W-1:0] cnt_lo_o,
  output logic [WORD_W-1:0] cnt_hi_o
);

  logic [WORD_W-1:0] cnt_lo_q, cnt_hi_q;
  logic              lo_wrap;

  assign lo_wrap = &cnt_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else begin
      cnt_lo_q <= cnt_lo_q + WORD_W'(1);
      if (lo_wrap) cnt_hi_q <= cnt_hi_q + WORD_W'(1);
    end
  end

  assign cnt_lo_o = cnt_lo_q;
  assign cnt_hi_o = cnt_hi_q;

  logic past_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_q <= 1'b0;
    else         past_q <= 1'b1;
  end

  // R2
  cnt_lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_q |-> cnt_lo_o == WORD_W'($past(cnt_lo_o) + WORD_W'(1)));

  // R3
  cnt_hi_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && (&$past(cnt_lo_o))) |-> cnt_hi_o == WORD_W'($past(cnt_hi_o) + WORD_W'(1)));

  // R3
  cnt_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && !(&$past(cnt_lo_o))) |-> $stable(cnt_hi_o));

endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare
  import mtimer_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] cmp_lo_o,
  output logic [WORD_W-1:0] cmp_hi_o
);

  localparam int unsigned NUM_HALVES = 2;

  logic [NUM_HALVES-1:0][WORD_W-1:0] cmp_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam reg_sel_e HALF_SEL = (h == 0) ? SEL_CMP_LO : SEL_CMP_HI;
    logic hit;
    assign hit = wr_en_i && (sel_i == HALF_SEL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cmp_q[h] <= '0;
      else if (hit) cmp_q[h] <= wr_data_i;
    end
  end

  assign cmp_lo_o = cmp_q[0];
  assign cmp_hi_o = cmp_q[1];

  // R6
  cmp_lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CMP_LO) |=> cmp_lo_o == $past(wr_data_i));

  // R6
  cmp_hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CMP_HI) |=> cmp_hi_o == $past(wr_data_i));

  // R7
  cmp_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (sel_i == SEL_CMP_LO || sel_i == SEL_CMP_HI))
      |=> ($stable(cmp_lo_o) && $stable(cmp_hi_o)));

endmodule

// File: rtl/mtimer_fire.sv
module mtimer_fire #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] cnt_lo_i,
  input  logic [WORD_W-1:0] cnt_hi_i,
  input  logic [WORD_W-1:0] cmp_lo_i,
  input  logic [WORD_W-1:0] cmp_hi_i,
  output logic              irq_o
);

  logic armed, hi_above, exact;

  // zero compare disarms the request
  assign armed    = (|cmp_lo_i) || (|cmp_hi_i);
  assign hi_above = cnt_hi_i > cmp_hi_i;
  assign exact    = (cnt_hi_i == cmp_hi_i) && (cnt_lo_i == cmp_lo_i);
  assign irq_o    = armed && (hi_above || exact);

endmodule

// File: rtl/mtimer.sv
module mtimer
  import mtimer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       WORD_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h0200_0000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);

  reg_sel_e          sel;
  logic [WORD_W-1:0] cnt_lo, cnt_hi, cmp_lo, cmp_hi;
  logic [WORD_W-1:0] rd_mux, rd_q;

  mtimer_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  mtimer_counter #(.WORD_W(WORD_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_lo_o (cnt_lo),
    .cnt_hi_o (cnt_hi)
  );

  mtimer_compare #(.WORD_W(WORD_W)) u_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .sel_i     (sel),
    .wr_data_i (wr_data_i),
    .cmp_lo_o  (cmp_lo),
    .cmp_hi_o  (cmp_hi)
  );

  mtimer_fire #(.WORD_W(WORD_W)) u_fire (
    .cnt_lo_i (cnt_lo),
    .cnt_hi_i (cnt_hi),
    .cmp_lo_i (cmp_lo),
    .cmp_hi_i (cmp_hi),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CMP_LO: rd_mux = cmp_lo;
      SEL_CMP_HI: rd_mux = cmp_hi;
      SEL_CNT_LO: rd_mux = cnt_lo;
      SEL_CNT_HI: rd_mux = cnt_hi;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R9
  rd_undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_NONE) |=> rd_data_o == '0);

  // R8
  rd_cnt_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_CNT_LO) |=> rd_data_o == $past(cnt_lo));

  // R5
  zero_cmp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_lo == '0 && cmp_hi == '0) |-> !irq_o);

  // R11
  match_then_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cnt_hi == cmp_hi && !(&cnt_lo) && !wr_en_i) |=> !irq_o);

endmodule

// File: tb/mtimer_tb.sv
module mtimer_tb;

  localparam int unsigned TW   = 4;
  localparam int unsigned AW   = 32;
  localparam logic [31:0] BASE = 32'h0200_0000;
  localparam logic [31:0] A_CLO = BASE + 32'h4000;
  localparam logic [31:0] A_CHI = BASE + 32'h4004;
  localparam logic [31:0] A_KLO = BASE + 32'hBFF8;
  localparam logic [31:0] A_KHI = BASE + 32'hBFFC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [TW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [TW-1:0] rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;

  always #10ns clk = ~clk;  // 50 MHz

  mtimer #(.ADDR_W(AW), .WORD_W(TW), .BASE_ADDR(BASE)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  // reference model from the requirements
  logic [2*TW-1:0] m_cnt, m_cmp;
  logic            rd_pend;
  logic [TW-1:0]   exp_rd;
  int              rd_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '0; rd_pend <= 1'b0; exp_rd <= '0; rd_kind <= 0;
    end else begin
      m_cnt <= m_cnt + 1'b1;
      if (wr_en) begin
        if (addr == A_CLO) m_cmp[TW-1:0]    <= wr_data;
        if (addr == A_CHI) m_cmp[2*TW-1:TW] <= wr_data;
      end
      rd_pend <= rd_en;
      if (rd_en) begin
        if      (addr == A_CLO) begin exp_rd <= m_cmp[TW-1:0];    rd_kind <= 1; end
        else if (addr == A_CHI) begin exp_rd <= m_cmp[2*TW-1:TW]; rd_kind <= 1; end
        else if (addr == A_KLO) begin exp_rd <= m_cnt[TW-1:0];    rd_kind <= 2; end
        else if (addr == A_KHI) begin exp_rd <= m_cnt[2*TW-1:TW]; rd_kind <= 3; end
        else                    begin exp_rd <= '0;               rd_kind <= 4; end
      end
    end
  end

  function automatic logic fire(input logic [2*TW-1:0] k, input logic [2*TW-1:0] c);
    return (c != '0) && ((k[2*TW-1:TW] > c[2*TW-1:TW]) || (k == c));
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle; per-cycle checks of irq and any pending read
  task automatic tick();
    @(negedge clk);
    if (chk_en) begin
      check(irq == fire(m_cnt, m_cmp), (m_cmp == '0) ? "R5 irq" : "R4 R11 irq",
            int'(irq), int'(fire(m_cnt, m_cmp)));
      if (rd_pend) begin
        case (rd_kind)
          1: check(rd_data == exp_rd, "R6 R8 cmp read", int'(rd_data), int'(exp_rd));
          2: check(rd_data == exp_rd, "R2 R8 cnt lo read", int'(rd_data), int'(exp_rd));
          3: check(rd_data == exp_rd, "R3 R8 cnt hi read", int'(rd_data), int'(exp_rd));
          default: check(rd_data == exp_rd, "R9 undef read", int'(rd_data), int'(exp_rd));
        endcase
      end
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [TW-1:0] d);
    rd_en = 1'b0; wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [TW-1:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    tick();
    check(rd_data == e, tag, int'(rd_data), int'(e));
  endtask

  function automatic logic [AW-1:0] rd_addr(input int k);
    case (k % 7)
      0: return A_CLO;
      1: return A_CHI;
      2: return A_KLO;
      3: return A_KHI;
      4: return BASE;
      5: return BASE + 32'h4008;
      default: return BASE + 32'hBFF4;
    endcase
  endfunction

  initial begin
    fork
      begin
        // R1: reset state
        rd_en = 1'b1; addr = A_KLO;
        repeat (3) begin
          @(negedge clk);
          check(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
          check(rd_data == '0, "R1 rd_data in reset", int'(rd_data), 0);
        end
        rd_en = 1'b0;
        rst_n = 1'b1;
        chk_en = 1'b1;
        rd_chk(A_CLO, '0, "R1 cmp lo after reset");
        rd_chk(A_CHI, '0, "R1 cmp hi after reset");
        rd_chk(A_KHI, '0, "R1 cnt hi after reset");

        // R4 R5 R6 R8 R9: every compare value over a full count period
        for (int c = 0; c < 256; c++) begin
          bus_wr(A_CLO, TW'(c));
          bus_wr(A_CHI, TW'(c >> TW));
          for (int k = 0; k < 256; k++) begin
            rd_en = 1'b1; addr = rd_addr(k + c);
            tick();
          end
          rd_en = 1'b0;
        end

        // R10: active request dropped by a compare rewrite
        bus_wr(A_CHI, '0);
        bus_wr(A_CLO, TW'(1));
        for (int i = 0; i < 20 && m_cnt[2*TW-1:TW] == '0; i++) tick();
        for (int i = 0; i < 20 && m_cnt[2*TW-1:TW] == '1; i++) tick();
        check(irq == 1'b1, "R10 request raised", int'(irq), 1);
        bus_wr(A_CHI, '1);
        check(irq == fire(m_cnt, m_cmp) && (m_cnt == 8'hF1 || !irq), "R10 request dropped",
              int'(irq), 0);

        // R11: match placed just ahead of the count
        for (int i = 0; i < 300 && m_cnt != 8'h10; i++) tick();
        bus_wr(A_CLO, TW'(6));
        bus_wr(A_CHI, TW'(1));
        for (int i = 0; i < 10 && m_cnt != 8'h16; i++) begin
          check(irq == 1'b0, "R11 before match", int'(irq), 0);
          tick();
        end
        check(irq == 1'b1, "R11 at match", int'(irq), 1);
        tick();
        check(irq == 1'b0, "R11 after match", int'(irq), 0);

        // R7: writes to non-writable offsets
        bus_wr(A_KLO, TW'(3));
        bus_wr(A_KHI, TW'(9));
        bus_wr(BASE, TW'(5));
        bus_wr(BASE + 32'h4008, TW'(7));
        bus_wr(BASE + 32'h3FFC, TW'(2));
        rd_chk(A_CLO, TW'(6), "R7 cmp lo unchanged");
        rd_chk(A_CHI, TW'(1), "R7 cmp hi unchanged");
        begin
          logic [TW-1:0] e_lo;
          e_lo = m_cnt[TW-1:0];
          rd_chk(A_KLO, e_lo, "R7 count unaffected");
        end
        tick();
      end
      begin
        #(20ns * 300000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule